// File: doc/BRIEF.md
# Performance Monitor Sample Address Capture

This block keeps two privileged 32-bit registers that record where the processor was when a performance monitor interrupt condition arose. One register keeps an instruction address and the other an operand address. The block watches a per-cycle stream of completing instruction addresses and operand addresses. It also watches a threshold-event pulse, which carries the exact instruction and operand that drove a counter negative, and a general interrupt-condition strobe for every other cause.

The cause of a capture decides which pair is latched. A threshold event records the exact offending pair. A general cause records the instruction that completed in that cycle together with an operand address seen at about the same time. The two addresses of a general capture need not belong together. If nothing completes in the capture cycle, shadow registers supply the most recent addresses.

After a capture the block holds a pending condition, and both registers stay frozen until software releases them. The interrupt request is the pending condition gated by an external interrupt enable. Software reaches the registers through a special-register access port. That port checks privilege and returns read data one cycle after the request.

A two-state controller runs the block:
- **OPEN**: capture is allowed. The transition *capture* leads to **HELD**.
- **HELD**: the sample is frozen. The transition *release* (a privileged write or an explicit clear) leads back to **OPEN**.

If a privileged write arrives in OPEN, the state stays OPEN. This is the transition *write-over-capture*.

Top module: `perf_sample_capture`

## Requirements
- R1: After reset both sampled registers read zero, the interrupt request is low and the fault flag is low.
- R2: In OPEN, a threshold pulse loads the instruction register with the threshold instruction address and the data register with the threshold operand address, then enters HELD.
- R3: In OPEN with no threshold pulse, a general strobe loads the instruction register with the completing address if an instruction completes that cycle. It loads the data register with the operand address if one is valid that cycle. It then enters HELD.
- R4: For a general strobe with no completion in that cycle, the instruction register takes the most recently completed address. With no valid operand in that cycle, the data register takes the most recent operand address. Both of these recent addresses are zero after reset.
- R5: When a threshold pulse and a general strobe fall in the same cycle, the threshold pair is captured.
- R6: In HELD, threshold and general events change neither register.
- R7: In HELD, a privileged write to either sampled register, or a pulse on the clear input, returns the block to OPEN. Later events then capture again.
- R8: The interrupt request is high exactly when the block is in HELD and the external enable is high.
- R9: Special register 955 selects the instruction register and 959 selects the data register. A privileged read returns the value on rd_data_o in the cycle after the request. A privileged write stores the write data, and rd_data_o is then zero in the following cycle.
- R10: An access to 955 or 959 without privilege raises acc_fault_o in the following cycle with rd_data_o zero, and a write of this kind changes nothing.
- R11: Any other register number, including the mode control number 952, is not claimed. It gives no fault and zero read data, and a write to it changes nothing.
- R12: A privileged write in OPEN in the same cycle as a threshold pulse or general strobe stores the written value. That cycle's capture is dropped entirely and the block stays OPEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cmp_vld_i | input | 1 | An instruction completes this cycle |
| cmp_iaddr_i | input | 32 | Effective address of the completing instruction |
| opd_vld_i | input | 1 | An operand address is valid this cycle |
| opd_daddr_i | input | 32 | Operand effective address |
| thr_evt_i | input | 1 | Threshold event pulse |
| thr_iaddr_i | input | 32 | Instruction address of the threshold event |
| thr_daddr_i | input | 32 | Operand address of the threshold event |
| gen_cond_i | input | 1 | Interrupt condition from a non-threshold cause |
| pend_clr_i | input | 1 | Explicit release of the pending condition |
| ext_en_i | input | 1 | External interrupt enable |
| acc_en_i | input | 1 | Special register access request |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_spr_i | input | 10 | Special register number |
| acc_sup_i | input | 1 | Requester holds supervisor privilege |
| acc_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, one cycle after the request |
| acc_fault_o | output | 1 | Privilege fault, one cycle after the request |
| irq_o | output | 1 | Interrupt request |

## Verification
Three pairs of functions can fall in the same cycle. A threshold capture can coincide with a general capture. A privileged register write can coincide with either capture. A release can coincide with new events. The bench sweeps every combination of threshold pulse, general strobe, completion valid and operand valid, under both enable values. For each combination it predicts the latched pair arithmetically from the distinct addresses it drives, and it then fires a second event burst to confirm the freeze. Directed cases write a register in the capture cycle and check that the written value survives, that the other register keeps its value and that no request rises.

// File: rtl/perf_sample_pkg.sv
package perf_sample_pkg;

    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_HELD = 1'b1
    } psc_state_e;

    localparam int unsigned PSC_LANES = 2;
    localparam int unsigned LANE_INSN = 0;
    localparam int unsigned LANE_DATA = 1;

endpackage

// File: rtl/psc_shadow.sv
// Keeps the most recent valid address of one lane.
module psc_shadow #(
    parameter int unsigned AW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          vld_i,
    input  logic [AW-1:0] d_i,
    output logic [AW-1:0] q_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q_o <= '0;
        else if (vld_i) q_o <= d_i;
    end
endmodule

// File: rtl/psc_spr_port.sv
// Decodes special register numbers, checks privilege and registers the read data.
module psc_spr_port #(
    parameter int unsigned AW     = 32,
    parameter int unsigned SPR_W  = 10,
    parameter int unsigned SPR_IA = 955,
    parameter int unsigned SPR_DA = 959
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             acc_en_i,
    input  logic             acc_wr_i,
    input  logic [SPR_W-1:0] acc_spr_i,
    input  logic             acc_sup_i,
    input  logic [AW-1:0]    sia_i,
    input  logic [AW-1:0]    sda_i,
    output logic             wr_ia_o,
    output logic             wr_da_o,
    output logic [AW-1:0]    rd_data_o,
    output logic             fault_o
);
    logic          hit_ia, hit_da, ok_rd;
    logic [AW-1:0] rd_nxt;
    logic          fault_nxt;

    always_comb begin
        hit_ia    = acc_en_i && (acc_spr_i == SPR_W'(SPR_IA));
        hit_da    = acc_en_i && (acc_spr_i == SPR_W'(SPR_DA));
        ok_rd     = acc_sup_i && !acc_wr_i;
        wr_ia_o   = hit_ia && acc_sup_i && acc_wr_i;
        wr_da_o   = hit_da && acc_sup_i && acc_wr_i;
        fault_nxt = (hit_ia || hit_da) && !acc_sup_i;
        rd_nxt    = '0;
        if (hit_ia && ok_rd)      rd_nxt = sia_i;
        else if (hit_da && ok_rd) rd_nxt = sda_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_data_o <= '0;
            fault_o   <= 1'b0;
        end else begin
            rd_data_o <= rd_nxt;
            fault_o   <= fault_nxt;
        end
    end
endmodule

// File: rtl/psc_ctrl.sv
// Capture controller: OPEN accepts a sample, HELD freezes it until released.
module psc_ctrl
    import perf_sample_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          thr_evt_i,
    input  logic [AW-1:0] thr_iaddr_i,
    input  logic [AW-1:0] thr_daddr_i,
    input  logic          gen_cond_i,
    input  logic [AW-1:0] gen_iaddr_i,
    input  logic [AW-1:0] gen_daddr_i,
    input  logic          pend_clr_i,
    input  logic          wr_ia_i,
    input  logic          wr_da_i,
    input  logic [AW-1:0] wdata_i,
    output logic [AW-1:0] sia_o,
    output logic [AW-1:0] sda_o,
    output logic          held_o
);
    psc_state_e st_q, st_d;
    logic       cap_thr, cap_gen, sw_wr;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_OPEN;
        else         st_q <= st_d;
    end

    // next state and capture decode
    always_comb begin
        sw_wr   = wr_ia_i || wr_da_i;
        st_d    = st_q;
        cap_thr = 1'b0;
        cap_gen = 1'b0;
        unique case (st_q)
            ST_OPEN: begin
                if (sw_wr) begin
                    st_d = ST_OPEN;            // write-over-capture
                end else if (thr_evt_i) begin
                    cap_thr = 1'b1;            // capture (threshold)
                    st_d    = ST_HELD;
                end else if (gen_cond_i) begin
                    cap_gen = 1'b1;            // capture (general)
                    st_d    = ST_HELD;
                end
            end
            ST_HELD: begin
                if (sw_wr || pend_clr_i) st_d = ST_OPEN;   // release
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sia_o <= '0;
            sda_o <= '0;
        end else begin
            if (wr_ia_i)      sia_o <= wdata_i;
            else if (cap_thr) sia_o <= thr_iaddr_i;
            else if (cap_gen) sia_o <= gen_iaddr_i;

            if (wr_da_i)      sda_o <= wdata_i;
            else if (cap_thr) sda_o <= thr_daddr_i;
            else if (cap_gen) sda_o <= gen_daddr_i;
        end
    end

    assign held_o = (st_q == ST_HELD);
endmodule

// File: rtl/perf_sample_capture.sv
module perf_sample_capture
    import perf_sample_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned SPR_W  = 10,
    parameter int unsigned SPR_IA = 955,
    parameter int unsigned SPR_DA = 959
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmp_vld_i,
    input  logic [AW-1:0]    cmp_iaddr_i,
    input  logic             opd_vld_i,
    input  logic [AW-1:0]    opd_daddr_i,
    input  logic             thr_evt_i,
    input  logic [AW-1:0]    thr_iaddr_i,
    input  logic [AW-1:0]    thr_daddr_i,
    input  logic             gen_cond_i,
    input  logic             pend_clr_i,
    input  logic             ext_en_i,
    input  logic             acc_en_i,
    input  logic             acc_wr_i,
    input  logic [SPR_W-1:0] acc_spr_i,
    input  logic             acc_sup_i,
    input  logic [AW-1:0]    acc_wdata_i,
    output logic [AW-1:0]    rd_data_o,
    output logic             acc_fault_o,
    output logic             irq_o
);
    logic          lane_v   [PSC_LANES];
    logic [AW-1:0] lane_d   [PSC_LANES];
    logic [AW-1:0] lane_shd [PSC_LANES];
    logic [AW-1:0] lane_pick[PSC_LANES];

    logic [AW-1:0] sia_q, sda_q;
    logic          wr_ia, wr_da, held;

    assign lane_v[LANE_INSN] = cmp_vld_i;
    assign lane_d[LANE_INSN] = cmp_iaddr_i;
    assign lane_v[LANE_DATA] = opd_vld_i;
    assign lane_d[LANE_DATA] = opd_daddr_i;

    // one shadow per lane; the live value wins over the shadow
    for (genvar g = 0; g < PSC_LANES; g++) begin : g_lane
        psc_shadow #(.AW(AW)) u_shd (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .vld_i  (lane_v[g]),
            .d_i    (lane_d[g]),
            .q_o    (lane_shd[g])
        );
        assign lane_pick[g] = lane_v[g] ? lane_d[g] : lane_shd[g];
    end

    psc_spr_port #(
        .AW(AW), .SPR_W(SPR_W), .SPR_IA(SPR_IA), .SPR_DA(SPR_DA)
    ) u_port (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .acc_en_i  (acc_en_i),
        .acc_wr_i  (acc_wr_i),
        .acc_spr_i (acc_spr_i),
        .acc_sup_i (acc_sup_i),
        .sia_i     (sia_q),
        .sda_i     (sda_q),
        .wr_ia_o   (wr_ia),
        .wr_da_o   (wr_da),
        .rd_data_o (rd_data_o),
        .fault_o   (acc_fault_o)
    );

    psc_ctrl #(.AW(AW)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .thr_evt_i   (thr_evt_i),
        .thr_iaddr_i (thr_iaddr_i),
        .thr_daddr_i (thr_daddr_i),
        .gen_cond_i  (gen_cond_i),
        .gen_iaddr_i (lane_pick[LANE_INSN]),
        .gen_daddr_i (lane_pick[LANE_DATA]),
        .pend_clr_i  (pend_clr_i),
        .wr_ia_i     (wr_ia),
        .wr_da_i     (wr_da),
        .wdata_i     (acc_wdata_i),
        .sia_o       (sia_q),
        .sda_o       (sda_q),
        .held_o      (held)
    );

    assign irq_o = held && ext_en_i;
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int unsigned AW     = 32,
    parameter int unsigned SPR_W  = 10,
    parameter int unsigned SPR_IA = 955,
    parameter int unsigned SPR_DA = 959
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             thr_evt_i,
    input logic [AW-1:0]    thr_iaddr_i,
    input logic [AW-1:0]    thr_daddr_i,
    input logic             gen_cond_i,
    input logic             pend_clr_i,
    input logic             ext_en_i,
    input logic             acc_en_i,
    input logic             acc_wr_i,
    input logic [SPR_W-1:0] acc_spr_i,
    input logic             acc_sup_i,
    input logic [AW-1:0]    rd_data_o,
    input logic             acc_fault_o,
    input logic             irq_o,
    input logic             held,
    input logic [AW-1:0]    sia_q,
    input logic [AW-1:0]    sda_q
);
    logic claimed, priv_wr;
    assign claimed = acc_en_i && (acc_spr_i == SPR_W'(SPR_IA) || acc_spr_i == SPR_W'(SPR_DA));
    assign priv_wr = claimed && acc_wr_i && acc_sup_i;

    a_r8_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (ext_en_i && held));

    a_r2_threshold_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!held && thr_evt_i && !priv_wr) |=>
            (held && sia_q == $past(thr_iaddr_i) && sda_q == $past(thr_daddr_i)));

    a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held && !pend_clr_i && !priv_wr) |=> (held && $stable(sia_q) && $stable(sda_q)));

    a_r10_fault_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claimed && !acc_sup_i) |=> (acc_fault_o && rd_data_o == '0));

    a_r11_unclaimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_en_i && !claimed) |=> (!acc_fault_o && rd_data_o == '0));

    a_r12_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!held && priv_wr && (thr_evt_i || gen_cond_i)) |=> !held);
endmodule

bind perf_sample_capture psc_checker #(
    .AW(AW), .SPR_W(SPR_W), .SPR_IA(SPR_IA), .SPR_DA(SPR_DA)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .thr_evt_i   (thr_evt_i),
    .thr_iaddr_i (thr_iaddr_i),
    .thr_daddr_i (thr_daddr_i),
    .gen_cond_i  (gen_cond_i),
    .pend_clr_i  (pend_clr_i),
    .ext_en_i    (ext_en_i),
    .acc_en_i    (acc_en_i),
    .acc_wr_i    (acc_wr_i),
    .acc_spr_i   (acc_spr_i),
    .acc_sup_i   (acc_sup_i),
    .rd_data_o   (rd_data_o),
    .acc_fault_o (acc_fault_o),
    .irq_o       (irq_o),
    .held        (held),
    .sia_q       (sia_q),
    .sda_q       (sda_q)
);

// File: tb/perf_sample_capture_tb.sv
module perf_sample_capture_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] N_IA  = 10'd955;
    localparam logic [9:0] N_DA  = 10'd959;
    localparam logic [9:0] N_MOD = 10'd952;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cmp_vld_i, opd_vld_i, thr_evt_i, gen_cond_i, pend_clr_i, ext_en_i;
    logic [31:0] cmp_iaddr_i, opd_daddr_i, thr_iaddr_i, thr_daddr_i, acc_wdata_i;
    logic        acc_en_i, acc_wr_i, acc_sup_i;
    logic [9:0]  acc_spr_i;
    logic [31:0] rd_data_o;
    logic        acc_fault_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    perf_sample_capture dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        cmp_vld_i = 0; opd_vld_i = 0; thr_evt_i = 0; gen_cond_i = 0; pend_clr_i = 0;
        acc_en_i = 0; acc_wr_i = 0; acc_sup_i = 0; acc_spr_i = '0; acc_wdata_i = '0;
        cmp_iaddr_i = '0; opd_daddr_i = '0; thr_iaddr_i = '0; thr_daddr_i = '0;
    endtask

    task automatic tick();
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic spr(input logic [9:0] n, input bit wr, input bit sup, input logic [31:0] wd,
                       output logic [31:0] rd, output logic flt);
        acc_en_i = 1; acc_wr_i = wr; acc_spr_i = n; acc_sup_i = sup; acc_wdata_i = wd;
        tick();
        rd = rd_data_o; flt = acc_fault_o;
        acc_en_i = 0; acc_wr_i = 0; acc_sup_i = 0; acc_wdata_i = '0;
    endtask

    task automatic expect_regs(input logic [31:0] ei, input logic [31:0] ed, input string req);
        logic [31:0] d; logic f;
        spr(N_IA, 0, 1, '0, d, f);
        chk(d == ei && !f, req, d, ei);
        spr(N_DA, 0, 1, '0, d, f);
        chk(d == ed && !f, req, d, ed);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] m_sia, m_sda, d, s_i, s_d, w;
        logic f;
        bit m_pend;
        quiet(); ext_en_i = 0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1;
        @(negedge clk_i);

        // R1: reset state
        chk(irq_o == 0, "R1 irq", {31'd0, irq_o}, 0);
        chk(acc_fault_o == 0, "R1 fault", {31'd0, acc_fault_o}, 0);
        expect_regs(0, 0, "R1 regs");

        // R4: general strobe before any completion picks zero shadows
        gen_cond_i = 1; tick(); quiet();
        expect_regs(0, 0, "R4 zero shadow");
        pend_clr_i = 1; tick(); quiet();
        m_sia = 0; m_sda = 0; m_pend = 0;

        // sweep: thr, gen, cmp valid, opd valid, under both enables
        for (int en = 0; en < 2; en++) begin
            for (int c = 0; c < 16; c++) begin
                bit thr, gen, cv, ov;
                thr = c[0]; gen = c[1]; cv = c[2]; ov = c[3];
                ext_en_i = en[0];
                // prime the shadows
                s_i = 32'h1000_0000 + 32'(c * 16 + en);
                s_d = 32'h2000_0000 + 32'(c * 16 + en);
                cmp_vld_i = 1; cmp_iaddr_i = s_i; opd_vld_i = 1; opd_daddr_i = s_d;
                tick(); quiet();
                // event cycle
                thr_evt_i = thr; gen_cond_i = gen;
                cmp_vld_i = cv; opd_vld_i = ov;
                thr_iaddr_i = 32'hA000_0000 | 32'(c); thr_daddr_i = 32'hB000_0000 | 32'(c);
                cmp_iaddr_i = 32'hC000_0000 | 32'(c); opd_daddr_i = 32'hD000_0000 | 32'(c);
                tick();
                if (thr) begin
                    m_sia = thr_iaddr_i; m_sda = thr_daddr_i; m_pend = 1;      // R2 R5
                end else if (gen) begin
                    m_sia = cv ? cmp_iaddr_i : s_i;                              // R3 R4
                    m_sda = ov ? opd_daddr_i : s_d;
                    m_pend = 1;
                end
                quiet();
                chk(irq_o == (m_pend && en[0]), "R8 irq gate", {31'd0, irq_o}, {31'd0, m_pend && en[0]});
                expect_regs(m_sia, m_sda, thr ? "R2 R5 threshold pair" : (cv ? "R3 general pair" : "R4 shadow pair"));
                // second burst: frozen if pending, otherwise captures
                thr_evt_i = 1; gen_cond_i = 1; cmp_vld_i = 1; opd_vld_i = 1;
                thr_iaddr_i = 32'hE000_0000 | 32'(c); thr_daddr_i = 32'hF000_0000 | 32'(c);
                cmp_iaddr_i = 32'h5000_0000; opd_daddr_i = 32'h6000_0000;
                tick();
                if (!m_pend) begin
                    m_sia = thr_iaddr_i; m_sda = thr_daddr_i; m_pend = 1;
                end
                quiet();
                expect_regs(m_sia, m_sda, "R6 freeze");
                // release, alternating between write and clear
                ext_en_i = 1;
                if (c[0]) begin
                    w = 32'h7700_0000 | 32'(c);
                    spr(N_DA, 1, 1, w, d, f);
                    chk(d == 0 && !f, "R9 write returns zero", d, 0);
                    m_sda = w;
                end else begin
                    pend_clr_i = 1; tick(); quiet();
                end
                m_pend = 0;
                chk(irq_o == 0, "R7 released", {31'd0, irq_o}, 0);
                expect_regs(m_sia, m_sda, "R7 R9 after release");
            end
        end

        // R9: write both, read back
        spr(N_IA, 1, 1, 32'h1234_5678, d, f); m_sia = 32'h1234_5678;
        spr(N_DA, 1, 1, 32'h9ABC_DEF0, d, f); m_sda = 32'h9ABC_DEF0;
        expect_regs(m_sia, m_sda, "R9 rw");

        // R10: unprivileged access
        spr(N_IA, 0, 0, '0, d, f);
        chk(f == 1 && d == 0, "R10 read fault", {31'd0, f}, 1);
        spr(N_DA, 1, 0, 32'hDEAD_BEEF, d, f);
        chk(f == 1, "R10 write fault", {31'd0, f}, 1);
        expect_regs(m_sia, m_sda, "R10 no effect");

        // R11: unclaimed numbers
        spr(N_MOD, 0, 1, '0, d, f);
        chk(f == 0 && d == 0, "R11 mode read", d, 0);
        spr(N_MOD, 1, 1, 32'hFFFF_FFFF, d, f);
        chk(f == 0, "R11 mode write", {31'd0, f}, 0);
        spr(N_MOD, 1, 0, 32'hFFFF_FFFF, d, f);
        chk(f == 0, "R11 unpriv no fault", {31'd0, f}, 0);
        expect_regs(m_sia, m_sda, "R11 no effect");

        // R12: write in the capture cycle
        ext_en_i = 1;
        thr_evt_i = 1; gen_cond_i = 1;
        thr_iaddr_i = 32'h4444_0000; thr_daddr_i = 32'h4444_1111;
        acc_en_i = 1; acc_wr_i = 1; acc_sup_i = 1; acc_spr_i = N_IA; acc_wdata_i = 32'h3333_0000;
        tick(); quiet();
        m_sia = 32'h3333_0000;
        chk(irq_o == 0, "R12 no pending", {31'd0, irq_o}, 0);
        expect_regs(m_sia, m_sda, "R12 write wins");
        // still OPEN: next threshold captures
        thr_evt_i = 1; thr_iaddr_i = 32'h8888_0001; thr_daddr_i = 32'h8888_0002;
        tick(); quiet();
        chk(irq_o == 1, "R12 open after write", {31'd0, irq_o}, 1);
        expect_regs(32'h8888_0001, 32'h8888_0002, "R2 after R12");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule